// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor

This block adds or subtracts two normalized floating-point operands in four register-separated segments. Each operand has a sign bit, an unsigned exponent and a magnitude fraction. The fraction is read as a binary value below one: its value is `man / 2^MAN_W`, and an operand is `(-1)^sign x (man / 2^MAN_W) x 2^exp`. A normalized operand has the top fraction bit set.

The first segment compares the exponents and orders the operands. The second aligns the smaller operand. The third adds or subtracts the magnitudes. The fourth normalizes the result. One operation may enter on every clock. A valid bit travels with each operation through the segments.

The result uses the same format as the inputs and is truncated, not rounded. The exponent range is not checked: operations whose normalized exponent would leave `0 .. 2^EXP_W-1` are outside the defined range.

Top module: `fpadd_pipe4`

## Requirements
- R1: An operation presented with `in_valid=1` at a rising edge appears with `out_valid=1` after exactly four rising edges. One operation is accepted on every clock. `out_valid` is 0 in every cycle that carries no operation.
- R2: The exponent that goes forward is the larger of `a_exp` and `b_exp`. On equal exponents, operand A is taken as the larger one.
- R3: The operand with the smaller exponent is shifted right by the exponent difference, and the bits shifted out are dropped. A difference of `MAN_W` or more makes that operand zero, so the result equals the larger operand.
- R4: `in_op=0` computes A+B and `in_op=1` computes A-B, which inverts B's sign. Sign bit 0 means positive and 1 means negative. When the effective signs match, the magnitudes are added and the result takes that common sign.
- R5: When the effective signs differ, the smaller aligned magnitude is subtracted from the larger one. The result takes the sign of the larger aligned magnitude. If the two magnitudes are equal, the result is zero (see R8).
- R6: If the magnitude sum carries out of the fraction range, the fraction shifts right by one place, its lowest bit is dropped, and the exponent increases by one.
- R7: If the result has leading zero bits, the fraction shifts left by the number of leading zeros and the exponent decreases by the same count. Every nonzero result therefore has its top fraction bit set.
- R8: A zero magnitude result is output as sign 0, exponent 0 and fraction 0.
- R9: An active-low `rst_n` clears all valid bits at once, without waiting for a clock. Operations in flight when reset is asserted never appear at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs |
| in_op | input | 1 | 0 = add, 1 = subtract B from A |
| a_sign | input | 1 | Sign of operand A (1 = negative) |
| a_exp | input | EXP_W | Exponent of operand A |
| a_man | input | MAN_W | Normalized fraction of operand A |
| b_sign | input | 1 | Sign of operand B (1 = negative) |
| b_exp | input | EXP_W | Exponent of operand B |
| b_man | input | MAN_W | Normalized fraction of operand B |
| out_valid | output | 1 | Result present on the outputs |
| out_sign | output | 1 | Sign of the result |
| out_exp | output | EXP_W | Exponent of the result |
| out_man | output | MAN_W | Normalized fraction of the result |

## Verification
The bench builds the block with `EXP_W=6` and `MAN_W=8`. Exponents can then differ by far more than the fraction width, so alignment shifts of 7, 8 and 10 places test both sides of the point where the smaller operand is flushed to zero. An eight-bit fraction keeps every expected result small enough to work out by hand. These include a seven-place left normalization, a carry with a dropped bit, and sign changes when the subtrahend is larger. Operations are sent back to back, and then as single operations between idle cycles and around a reset, to test the fixed four-cycle latency.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
    typedef enum logic {
        FP_ADD = 1'b0,
        FP_SUB = 1'b1
    } fp_op_e;
endpackage

// File: rtl/fpadd_cmp.sv
module fpadd_cmp
    import fpadd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_v,
    input  logic             i_op,
    input  logic             i_a_sign,
    input  logic [EXP_W-1:0] i_a_exp,
    input  logic [MAN_W-1:0] i_a_man,
    input  logic             i_b_sign,
    input  logic [EXP_W-1:0] i_b_exp,
    input  logic [MAN_W-1:0] i_b_man,
    output logic             o_v,
    output logic [EXP_W-1:0] o_exp,
    output logic [EXP_W-1:0] o_shift,
    output logic [MAN_W-1:0] o_big_man,
    output logic             o_big_sign,
    output logic [MAN_W-1:0] o_sml_man,
    output logic             o_sml_sign
);
    typedef struct packed {
        logic             v;
        logic [EXP_W-1:0] exp;
        logic [EXP_W-1:0] shift;
        logic [MAN_W-1:0] big_man;
        logic             big_sign;
        logic [MAN_W-1:0] sml_man;
        logic             sml_sign;
    } cmp_t;

    cmp_t st_d, st_q;

    always_comb begin
        logic b_eff;
        b_eff = i_b_sign ^ (i_op == FP_SUB);
        st_d = '0;
        st_d.v = i_v;
        if (i_a_exp >= i_b_exp) begin
            st_d.exp      = i_a_exp;
            st_d.shift    = i_a_exp - i_b_exp;
            st_d.big_man  = i_a_man;
            st_d.big_sign = i_a_sign;
            st_d.sml_man  = i_b_man;
            st_d.sml_sign = b_eff;
        end else begin
            st_d.exp      = i_b_exp;
            st_d.shift    = i_b_exp - i_a_exp;
            st_d.big_man  = i_b_man;
            st_d.big_sign = b_eff;
            st_d.sml_man  = i_a_man;
            st_d.sml_sign = i_a_sign;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o_v        = st_q.v;
    assign o_exp      = st_q.exp;
    assign o_shift    = st_q.shift;
    assign o_big_man  = st_q.big_man;
    assign o_big_sign = st_q.big_sign;
    assign o_sml_man  = st_q.sml_man;
    assign o_sml_sign = st_q.sml_sign;

    a_r1_entry_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (o_v == $past(i_v)));

    a_r2_larger_exp: assert property (@(posedge clk) disable iff (!rst_n)
        i_v |=> (o_exp >= $past(i_a_exp) && o_exp >= $past(i_b_exp)));
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_v,
    input  logic [EXP_W-1:0] i_exp,
    input  logic [EXP_W-1:0] i_shift,
    input  logic [MAN_W-1:0] i_big_man,
    input  logic             i_big_sign,
    input  logic [MAN_W-1:0] i_sml_man,
    input  logic             i_sml_sign,
    output logic             o_v,
    output logic [EXP_W-1:0] o_exp,
    output logic [MAN_W-1:0] o_big_man,
    output logic             o_big_sign,
    output logic [MAN_W-1:0] o_sml_man,
    output logic             o_sml_sign
);
    localparam logic [EXP_W-1:0] FLUSH_AT = EXP_W'(MAN_W);

    typedef struct packed {
        logic             v;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] big_man;
        logic             big_sign;
        logic [MAN_W-1:0] sml_man;
        logic             sml_sign;
    } aln_t;

    aln_t st_d, st_q;

    always_comb begin
        st_d.v        = i_v;
        st_d.exp      = i_exp;
        st_d.big_man  = i_big_man;
        st_d.big_sign = i_big_sign;
        st_d.sml_sign = i_sml_sign;
        if (i_shift >= FLUSH_AT) st_d.sml_man = '0;
        else                     st_d.sml_man = i_sml_man >> i_shift;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o_v        = st_q.v;
    assign o_exp      = st_q.exp;
    assign o_big_man  = st_q.big_man;
    assign o_big_sign = st_q.big_sign;
    assign o_sml_man  = st_q.sml_man;
    assign o_sml_sign = st_q.sml_sign;

    a_r3_wide_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (i_v && i_shift >= FLUSH_AT) |=> (o_sml_man == '0));

    a_r3_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
        i_v |=> (o_sml_man <= $past(i_sml_man)));
endmodule

// File: rtl/fpadd_addsub.sv
module fpadd_addsub #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_v,
    input  logic [EXP_W-1:0] i_exp,
    input  logic [MAN_W-1:0] i_big_man,
    input  logic             i_big_sign,
    input  logic [MAN_W-1:0] i_sml_man,
    input  logic             i_sml_sign,
    output logic             o_v,
    output logic [EXP_W-1:0] o_exp,
    output logic [MAN_W:0]   o_sum,
    output logic             o_sign
);
    typedef struct packed {
        logic             v;
        logic [EXP_W-1:0] exp;
        logic [MAN_W:0]   sum;
        logic             sign;
    } add_t;

    add_t st_d, st_q;

    always_comb begin
        st_d.v   = i_v;
        st_d.exp = i_exp;
        if (i_big_sign == i_sml_sign) begin
            st_d.sum  = {1'b0, i_big_man} + {1'b0, i_sml_man};
            st_d.sign = i_big_sign;
        end else if (i_big_man >= i_sml_man) begin
            st_d.sum  = {1'b0, i_big_man - i_sml_man};
            st_d.sign = i_big_sign;
        end else begin
            st_d.sum  = {1'b0, i_sml_man - i_big_man};
            st_d.sign = i_sml_sign;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o_v    = st_q.v;
    assign o_exp  = st_q.exp;
    assign o_sum  = st_q.sum;
    assign o_sign = st_q.sign;

    a_r4_same_sign_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (i_v && i_big_sign == i_sml_sign) |=> (o_sum >= {1'b0, $past(i_big_man)}));

    a_r5_diff_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (i_v && i_big_sign != i_sml_sign) |=> !o_sum[MAN_W]);
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_v,
    input  logic [EXP_W-1:0] i_exp,
    input  logic [MAN_W:0]   i_sum,
    input  logic             i_sign,
    output logic             o_v,
    output logic             o_sign,
    output logic [EXP_W-1:0] o_exp,
    output logic [MAN_W-1:0] o_man
);
    localparam int CNT_W = $clog2(MAN_W + 1);

    typedef struct packed {
        logic             v;
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } nrm_t;

    nrm_t st_d, st_q;

    function automatic logic [CNT_W-1:0] lead_zeros(input logic [MAN_W-1:0] m);
        logic [CNT_W-1:0] cnt;
        logic             hit;
        cnt = '0;
        hit = 1'b0;
        for (int i = MAN_W - 1; i >= 0; i--) begin
            if (!hit) begin
                if (m[i]) hit = 1'b1;
                else      cnt = cnt + 1'b1;
            end
        end
        return cnt;
    endfunction

    always_comb begin
        logic [CNT_W-1:0] lz;
        lz = lead_zeros(i_sum[MAN_W-1:0]);
        st_d.v = i_v;
        if (i_sum[MAN_W]) begin
            st_d.sign = i_sign;
            st_d.man  = i_sum[MAN_W:1];
            st_d.exp  = i_exp + 1'b1;
        end else if (i_sum[MAN_W-1:0] == '0) begin
            st_d.sign = 1'b0;
            st_d.man  = '0;
            st_d.exp  = '0;
        end else begin
            st_d.sign = i_sign;
            st_d.man  = i_sum[MAN_W-1:0] << lz;
            st_d.exp  = i_exp - EXP_W'(lz);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o_v    = st_q.v;
    assign o_sign = st_q.sign;
    assign o_exp  = st_q.exp;
    assign o_man  = st_q.man;

    a_r6_carry_bumps_exp: assert property (@(posedge clk) disable iff (!rst_n)
        (i_v && i_sum[MAN_W]) |=> (o_exp == EXP_W'($past(i_exp) + 1'b1)));

    a_r7_top_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (o_v && o_man != '0) |-> o_man[MAN_W-1]);

    a_r8_zero_form: assert property (@(posedge clk) disable iff (!rst_n)
        (o_v && o_man == '0) |-> (o_exp == '0 && !o_sign));
endmodule

// File: rtl/fpadd_pipe4.sv
module fpadd_pipe4 #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_op,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [MAN_W-1:0] a_man,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [MAN_W-1:0] b_man,
    output logic             out_valid,
    output logic             out_sign,
    output logic [EXP_W-1:0] out_exp,
    output logic [MAN_W-1:0] out_man
);
    logic             c_v, c_big_sign, c_sml_sign;
    logic [EXP_W-1:0] c_exp, c_shift;
    logic [MAN_W-1:0] c_big_man, c_sml_man;

    logic             l_v, l_big_sign, l_sml_sign;
    logic [EXP_W-1:0] l_exp;
    logic [MAN_W-1:0] l_big_man, l_sml_man;

    logic             s_v, s_sign;
    logic [EXP_W-1:0] s_exp;
    logic [MAN_W:0]   s_sum;

    fpadd_cmp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .i_v(in_valid), .i_op(in_op),
        .i_a_sign(a_sign), .i_a_exp(a_exp), .i_a_man(a_man),
        .i_b_sign(b_sign), .i_b_exp(b_exp), .i_b_man(b_man),
        .o_v(c_v), .o_exp(c_exp), .o_shift(c_shift),
        .o_big_man(c_big_man), .o_big_sign(c_big_sign),
        .o_sml_man(c_sml_man), .o_sml_sign(c_sml_sign)
    );

    fpadd_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
        .clk(clk), .rst_n(rst_n), .i_v(c_v), .i_exp(c_exp), .i_shift(c_shift),
        .i_big_man(c_big_man), .i_big_sign(c_big_sign),
        .i_sml_man(c_sml_man), .i_sml_sign(c_sml_sign),
        .o_v(l_v), .o_exp(l_exp), .o_big_man(l_big_man), .o_big_sign(l_big_sign),
        .o_sml_man(l_sml_man), .o_sml_sign(l_sml_sign)
    );

    fpadd_addsub #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_addsub (
        .clk(clk), .rst_n(rst_n), .i_v(l_v), .i_exp(l_exp),
        .i_big_man(l_big_man), .i_big_sign(l_big_sign),
        .i_sml_man(l_sml_man), .i_sml_sign(l_sml_sign),
        .o_v(s_v), .o_exp(s_exp), .o_sum(s_sum), .o_sign(s_sign)
    );

    fpadd_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
        .clk(clk), .rst_n(rst_n), .i_v(s_v), .i_exp(s_exp), .i_sum(s_sum),
        .i_sign(s_sign), .o_v(out_valid), .o_sign(out_sign),
        .o_exp(out_exp), .o_man(out_man)
    );

    a_r1_valid_chain: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(s_v)));
endmodule

// File: tb/tb_fpadd_pipe4.sv
`timescale 1ns/1ps
module tb_fpadd_pipe4;
    localparam int EW = 6;
    localparam int MW = 8;
    localparam int NV = 14;
    localparam int RW = 3 * (1 + EW + MW) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_op = 1'b0;
    logic          a_sign = 1'b0, b_sign = 1'b0;
    logic [EW-1:0] a_exp = '0, b_exp = '0;
    logic [MW-1:0] a_man = '0, b_man = '0;
    logic          out_valid, out_sign;
    logic [EW-1:0] out_exp;
    logic [MW-1:0] out_man;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fpadd_pipe4 #(.EXP_W(EW), .MAN_W(MW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
        .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
        .out_valid(out_valid), .out_sign(out_sign),
        .out_exp(out_exp), .out_man(out_man)
    );

    // row: {op, a_sign, a_exp, a_man, b_sign, b_exp, b_man, r_sign, r_exp, r_man}
    localparam logic [RW-1:0] VEC [NV] = '{
        {1'b0, 1'b0, 6'd5,  8'h80, 1'b0, 6'd5,  8'h80, 1'b0, 6'd6,  8'h80}, // R6 carry
        {1'b0, 1'b0, 6'd10, 8'hA0, 1'b0, 6'd8,  8'h90, 1'b0, 6'd10, 8'hC4}, // R3 shift 2
        {1'b1, 1'b0, 6'd7,  8'hB0, 1'b0, 6'd7,  8'hB0, 1'b0, 6'd0,  8'h00}, // R8 zero
        {1'b1, 1'b0, 6'd9,  8'h80, 1'b0, 6'd8,  8'hF0, 1'b0, 6'd5,  8'h80}, // R7 lz 4
        {1'b1, 1'b0, 6'd3,  8'h90, 1'b0, 6'd3,  8'hC0, 1'b1, 6'd1,  8'hC0}, // R5 sign flips
        {1'b0, 1'b0, 6'd2,  8'h80, 1'b1, 6'd6,  8'hE0, 1'b1, 6'd6,  8'hD8}, // R2 B larger
        {1'b0, 1'b0, 6'd40, 8'hAB, 1'b0, 6'd30, 8'hFF, 1'b0, 6'd40, 8'hAB}, // R3 shift 10
        {1'b1, 1'b0, 6'd20, 8'h81, 1'b0, 6'd12, 8'hFF, 1'b0, 6'd20, 8'h81}, // R3 shift 8
        {1'b0, 1'b0, 6'd20, 8'h80, 1'b0, 6'd13, 8'hFF, 1'b0, 6'd20, 8'h81}, // R3 shift 7
        {1'b0, 1'b1, 6'd12, 8'hC0, 1'b1, 6'd12, 8'hC0, 1'b1, 6'd13, 8'hC0}, // R4 both neg
        {1'b1, 1'b0, 6'd1,  8'h80, 1'b1, 6'd1,  8'h80, 1'b0, 6'd2,  8'h80}, // R4 minus neg
        {1'b0, 1'b0, 6'd3,  8'hFF, 1'b0, 6'd3,  8'h82, 1'b0, 6'd4,  8'hC0}, // R6 bit dropped
        {1'b1, 1'b1, 6'd5,  8'h90, 1'b1, 6'd5,  8'hA0, 1'b0, 6'd2,  8'h80}, // R5 neg-neg
        {1'b1, 1'b0, 6'd10, 8'h80, 1'b0, 6'd9,  8'hFF, 1'b0, 6'd3,  8'h80}  // R7 lz 7
    };

    function automatic string row_tag(input int i);
        case (i)
            0, 11:         return "R6";
            1, 6, 7, 8:    return "R3";
            2:             return "R8";
            3, 13:         return "R7";
            4, 12:         return "R5";
            5:             return "R2";
            default:       return "R4";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic drive(input int i);
        logic [RW-1:0] r;
        r = VEC[i];
        in_valid = 1'b1;
        {in_op, a_sign, a_exp, a_man, b_sign, b_exp, b_man} = r[RW-1:1+EW+MW];
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: output quiet while reset is held
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9", {31'b0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", {31'b0, out_valid}, 32'd0);

        // R1: back-to-back stream, each result four edges later
        for (int c = 0; c < NV + 4; c++) begin
            @(negedge clk);
            if (c >= 4) begin
                logic [RW-1:0] r;
                logic [1+EW+MW-1:0] want;
                r = VEC[c-4];
                want = r[EW+MW:0];
                check(out_valid == 1'b1, "R1", {31'b0, out_valid}, 32'd1);
                check({out_sign, out_exp, out_man} == want, row_tag(c - 4),
                      32'({out_sign, out_exp, out_man}), 32'(want));
            end
            if (c < NV) drive(c);
            else        in_valid = 1'b0;
        end

        // R1: a single operation between idle cycles
        @(negedge clk);
        drive(1);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            check(out_valid == (k == 4), "R1", {31'b0, out_valid}, 32'(k == 4));
            if (k == 4)
                check({out_sign, out_exp, out_man} == {1'b0, 6'd10, 8'hC4}, "R1",
                      32'({out_sign, out_exp, out_man}), 32'({1'b0, 6'd10, 8'hC4}));
        end

        // R9: reset in flight drops the operation
        @(negedge clk);
        drive(0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check(out_valid == 1'b0, "R9", {31'b0, out_valid}, 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R9", {31'b0, out_valid}, 32'd0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule